// File: doc/BRIEF.md
# Masked-Byte CRC Wake-Frame Matcher

This block watches a received Ethernet frame as a byte stream (valid, start-of-frame and end-of-frame strobes next to an 8-bit data bus). It decides whether the frame carries a programmed wake-up pattern. It has two independent pattern slots. Each slot holds a 64-bit byte mask over the first 64 frame bytes and a 32-bit expected CRC. While the frame passes, every slot runs the standard Ethernet CRC-32, but only over the bytes its mask selects. When the end-of-frame byte arrives, each slot compares its finished CRC with its expected value and gives a one-cycle match pulse if they agree.

The slots are programmed through a small synchronous 16-bit register port. Each slot takes eight word addresses: the two halves of the expected CRC, four mask words and two unused words. At the start of each frame a slot takes a snapshot of its registers. Software can therefore rewrite a slot while a frame is being checked without disturbing that frame.

A two-state controller sets the byte position. In `ST_IDLE`, a valid byte with the start strobe opens a frame: it goes to `ST_FRAME`, or stays in `ST_IDLE` when the same byte also carries the end strobe (a one-byte frame). In `ST_FRAME`, a valid byte with the end strobe closes the frame and returns to `ST_IDLE`. A valid byte with the start strobe restarts the frame at byte 1 and stays in `ST_FRAME`. Any other valid byte advances the byte position and stays in `ST_FRAME`.

Top module: `wake_crc_matcher`

## Requirements
- R1: A register address is {slot, word}, where word is the low 3 bits. Word 0 holds expected-CRC bits 15:0 and word 1 holds bits 31:16. Words 2 to 5 hold mask words 0 to 3. All six are read/write. Words 6 and 7 read as zero. `reg_rdata` shows the word at the address presented on the previous clock edge.
- R2: After reset every register reads 0x0000 and `match_o` is low.
- R3: Bit b of mask word w selects frame byte 16*w + b + 1. Byte 1 is the byte that carries the start strobe.
- R4: A slot's value is the reflected CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, final inversion) over its selected bytes, taken in frame order. When that value equals {word1, word0}, the slot's `match_o` bit is high for exactly one cycle, the cycle after the end-of-frame byte is accepted.
- R5: Frame bytes after byte 64 never change any slot's CRC.
- R6: A frame that ends before the highest selected byte of a slot gives no match for that slot, even if the CRC over the bytes present agrees.
- R7: A slot whose mask is all zeros never matches.
- R8: The two slots are independent. Each sees only its own mask and expected CRC.
- R9: A register write made while a frame is in progress does not affect that frame. It applies from the next start of frame onward.
- R10: A valid byte outside a frame that has no start strobe is ignored, even if it carries the end strobe. A start strobe inside a frame restarts the check at byte 1.
- R11: A one-byte frame (start and end strobe on the same byte) is checked like any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte present on rx_data this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Received frame byte |
| reg_wr | input | 1 | Write strobe of the register port |
| reg_addr | input | 4 | Word address {slot, word} |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the address |
| match_o | output | 2 | One-cycle match pulse per slot |

## Verification
The bench walks a single selected byte through all 64 mask positions. A matcher with the bit order reversed inside a mask word, or with the mask words swapped, would then miss the match at most positions. Slot 0 is programmed correctly while slot 1 gets a corrupted CRC, and then the other way round. A design that mixes up the slots or ignores a CRC bit would then raise the wrong pulse. An all-zero mask is paired with an all-zero expected value. An unguarded design reports this empty CRC as a match, because the CRC over no bytes is zero after inversion. Other frames are built to catch a design that counts bytes past 64, accepts a frame too short for its mask, lets a write made mid-frame leak into the running check, or fails to restart on a second start strobe.

// File: rtl/wcm_pkg.sv
package wcm_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } wcm_state_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ d[k]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/wcm_regfile.sv
module wcm_regfile #(
    parameter int NUM_SLOTS  = 2,
    parameter int WORD_W     = 16,
    parameter int MASK_WORDS = 4,
    parameter int STRIDE_W   = 3,
    parameter int ADDR_W     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [WORD_W-1:0]                     wdata,
    output logic [WORD_W-1:0]                     rdata,
    output logic [NUM_SLOTS*MASK_WORDS*WORD_W-1:0] mask_flat,
    output logic [NUM_SLOTS*2*WORD_W-1:0]          crc_flat
);
    localparam int WPS     = MASK_WORDS + 2;
    localparam int ENTRIES = NUM_SLOTS * WPS;
    localparam int EIDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [WORD_W-1:0] mem [ENTRIES];
    logic              hit;
    logic [EIDX_W-1:0] eidx;

    always_comb begin
        int slot_i;
        int word_i;
        slot_i = int'(addr >> STRIDE_W);
        word_i = int'(addr[STRIDE_W-1:0]);
        hit    = (slot_i < NUM_SLOTS) && (word_i < WPS);
        eidx   = hit ? EIDX_W'(slot_i * WPS + word_i) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (wr && hit) mem[eidx] <= wdata;
            rdata <= hit ? mem[eidx] : '0;
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign crc_flat[(2*s)*WORD_W   +: WORD_W] = mem[s*WPS + 0];
        assign crc_flat[(2*s+1)*WORD_W +: WORD_W] = mem[s*WPS + 1];
        for (genvar k = 0; k < MASK_WORDS; k++) begin : g_mask
            assign mask_flat[(s*MASK_WORDS+k)*WORD_W +: WORD_W] = mem[s*WPS + 2 + k];
        end
    end

endmodule

// File: rtl/wcm_ctrl.sv
module wcm_ctrl #(
    parameter int MASK_BYTES = 64,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             beat,
    output logic             first,
    output logic             last,
    output logic [IDX_W-1:0] idx,
    output logic             in_frame,
    output logic [IDX_W-1:0] byte_cnt
);
    import wcm_pkg::*;

    wcm_state_e       state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        beat    = 1'b0;
        first   = 1'b0;
        last    = 1'b0;
        idx     = cnt_q;
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    beat  = 1'b1;
                    first = 1'b1;
                    idx   = '0;
                    last  = rx_eof;
                    state_d = rx_eof ? ST_IDLE : ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (rx_valid) begin
                    beat  = 1'b1;
                    first = rx_sof;
                    idx   = rx_sof ? '0 : cnt_q;
                    last  = rx_eof;
                    state_d = rx_eof ? ST_IDLE : ST_FRAME;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (beat) begin
            if (idx >= IDX_W'(MASK_BYTES)) cnt_d = IDX_W'(MASK_BYTES);
            else                           cnt_d = idx + IDX_W'(1);
        end
    end

    assign in_frame = (state_q == ST_FRAME);
    assign byte_cnt = cnt_q;

endmodule

// File: rtl/wcm_slot.sv
module wcm_slot #(
    parameter int MASK_BYTES = 64,
    parameter int IDX_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  beat,
    input  logic                  first,
    input  logic                  last,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            data,
    input  logic [MASK_BYTES-1:0] live_mask,
    input  logic [31:0]           live_exp,
    output logic                  match
);
    import wcm_pkg::*;

    logic [MASK_BYTES-1:0] snap_mask;
    logic [31:0]           snap_exp;
    logic [31:0]           crc_q;

    logic [MASK_BYTES-1:0] eff_mask;
    logic [31:0]           eff_exp;
    logic [31:0]           base;
    logic [31:0]           crc_nx;
    logic                  sel;
    logic                  tail_clear;
    logic                  hit;
    logic [IDX_W:0]        idx_p1;
    logic [MASK_BYTES-1:0] from_idx;
    logic [MASK_BYTES-1:0] above_idx;

    always_comb begin
        eff_mask   = first ? live_mask : snap_mask;
        eff_exp    = first ? live_exp  : snap_exp;
        base       = first ? CRC_SEED  : crc_q;
        from_idx   = eff_mask >> idx;
        sel        = (idx < IDX_W'(MASK_BYTES)) && from_idx[0];
        crc_nx     = sel ? crc_step(base, data) : base;
        idx_p1     = {1'b0, idx} + (IDX_W+1)'(1);
        above_idx  = eff_mask >> idx_p1;
        tail_clear = (above_idx == '0);
        hit        = last && (eff_mask != '0) && tail_clear && ((~crc_nx) == eff_exp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_mask <= '0;
            snap_exp  <= '0;
            crc_q     <= CRC_SEED;
            match     <= 1'b0;
        end else begin
            match <= beat && hit;
            if (beat) begin
                crc_q <= crc_nx;
                if (first) begin
                    snap_mask <= live_mask;
                    snap_exp  <= live_exp;
                end
            end
        end
    end

endmodule

// File: rtl/wake_crc_matcher.sv
module wake_crc_matcher #(
    parameter  int NUM_SLOTS  = 2,
    parameter  int WORD_W     = 16,
    parameter  int MASK_WORDS = 4,
    localparam int STRIDE_W   = 3,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 0,
    localparam int ADDR_W     = SLOT_W + STRIDE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_data,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_SLOTS-1:0] match_o
);
    localparam int MASK_BYTES = MASK_WORDS * WORD_W;
    localparam int IDX_W      = $clog2(MASK_BYTES) + 1;

    logic [NUM_SLOTS*MASK_BYTES-1:0] mask_flat;
    logic [NUM_SLOTS*2*WORD_W-1:0]   crc_flat;
    logic                            beat, first, last;
    logic [IDX_W-1:0]                idx;
    logic                            in_frame;
    logic [IDX_W-1:0]                byte_cnt;

    wcm_regfile #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORD_W    (WORD_W),
        .MASK_WORDS(MASK_WORDS),
        .STRIDE_W  (STRIDE_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mask_flat(mask_flat),
        .crc_flat (crc_flat)
    );

    wcm_ctrl #(
        .MASK_BYTES(MASK_BYTES),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_sof  (rx_sof),
        .rx_eof  (rx_eof),
        .beat    (beat),
        .first   (first),
        .last    (last),
        .idx     (idx),
        .in_frame(in_frame),
        .byte_cnt(byte_cnt)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        wcm_slot #(
            .MASK_BYTES(MASK_BYTES),
            .IDX_W     (IDX_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat     (beat),
            .first    (first),
            .last     (last),
            .idx      (idx),
            .data     (rx_data),
            .live_mask(mask_flat[s*MASK_BYTES +: MASK_BYTES]),
            .live_exp (crc_flat[s*2*WORD_W +: 2*WORD_W]),
            .match    (match_o[s])
        );
    end

endmodule

// File: rtl/wcm_checker.sv
module wcm_checker #(
    parameter int NUM_SLOTS  = 2,
    parameter int WORD_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int IDX_W      = 7,
    parameter int MASK_BYTES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 rx_sof,
    input logic                 rx_eof,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [WORD_W-1:0]    reg_wdata,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic [NUM_SLOTS-1:0] match_o,
    input logic                 in_frame,
    input logic [IDX_W-1:0]     byte_cnt
);
    // R4: a pulse only follows an accepted end-of-frame byte
    a_r4_match_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o != '0) |-> $past(rx_valid && rx_eof && (in_frame || rx_sof)));

    // R10: an idle end strobe without start never produces a pulse
    a_r10_idle_eof_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_frame && rx_valid && rx_eof && !rx_sof) |-> (match_o == '0));

    // R11: any accepted end-of-frame byte leaves the controller idle
    a_r11_eof_closes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && rx_eof && (in_frame || rx_sof)) |-> !in_frame);

    // R5: byte position stops counting at the mask length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= IDX_W'(MASK_BYTES));

    // R1: a written word is returned on a following read of the same address
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_wr, 2) && !$past(reg_wr) && ($past(reg_addr, 2) == $past(reg_addr))
         && ($past(reg_addr[2:0]) < 3'd6))
        |-> (reg_rdata == $past(reg_wdata, 2)));

endmodule

bind wake_crc_matcher wcm_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .MASK_BYTES(MASK_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .match_o  (match_o),
    .in_frame (in_frame),
    .byte_cnt (byte_cnt)
);

// File: tb/wake_crc_matcher_bench.sv
module wake_crc_matcher_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  match_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] fb [0:127];

    always #10 clk = ~clk;

    wake_crc_matcher u_wake_crc_matcher (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .match_o(match_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++)
            c = (c[0] ^ d[k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic logic [31:0] exp_crc(input logic [63:0] m, input int len);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 64; i++)
            if (i < len && m[i]) c = model_step(c, fb[i]);
        return ~c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) fb[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2) ^ (seed << 3));
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    // slot base = slot*8; word0 CRC low, word1 CRC high, words 2..5 mask words 0..3
    task automatic prog(input int s, input logic [63:0] m, input logic [31:0] c);
        wr(4'(s * 8 + 0), c[15:0]);
        wr(4'(s * 8 + 1), c[31:16]);
        for (int k = 0; k < 4; k++) wr(4'(s * 8 + 2 + k), m[16*k +: 16]);
    endtask

    task automatic send(input int len, input bit mid_wr, output logic [1:0] got, output logic [1:0] after);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fb[i];
            if (mid_wr && i >= 3 && i < 9) begin
                reg_wr = 1'b1; reg_addr = 4'(i - 3); reg_wdata = 16'hA5A5 ^ 16'(i);
            end else reg_wr = 1'b0;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        got = match_o;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        after = match_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [1:0]  g, a;
        logic [63:0] m;
        logic [31:0] c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 match after reset", 32'(match_o), 32'h0);
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 6; w++) begin
                rd(4'(s * 8 + w), d);
                chk("R2 register reset", 32'(d), 32'h0);
            end

        // R1: read/write sweep, unused words read zero
        for (int ad = 0; ad < 16; ad++) wr(4'(ad), 16'(16'h1357 * (ad + 1)));
        for (int ad = 0; ad < 16; ad++) begin
            rd(4'(ad), d);
            chk("R1 readback", 32'(d), (ad % 8 < 6) ? 32'(16'(16'h1357 * (ad + 1))) : 32'h0);
        end

        // R3: walk one selected byte through all 64 positions; R8 slot1 corrupted
        for (int p = 0; p < 64; p++) begin
            fill(p);
            m = 64'h1 << p;
            c = exp_crc(m, 64);
            prog(0, m, c);
            prog(1, m, c ^ 32'h1);
            send(64, 1'b0, g, a);
            chk("R3 single byte position", 32'(g), 32'h1);
            if (p % 16 == 0) chk("R4 pulse lasts one cycle", 32'(a), 32'h0);
        end

        // R4/R8: sparse masks, each slot corrupted in turn
        for (int t = 0; t < 8; t++) begin
            fill(100 + t);
            m = {32'(32'h9E3779B9 * (t + 1)), 32'(32'h85EBCA6B ^ (t * 32'h01010101))};
            c = exp_crc(m, 64);
            prog(0, m, c); prog(1, m, c ^ (32'h1 << (t * 4)));
            send(64, 1'b0, g, a);
            chk("R4 sparse mask slot0 only", 32'(g), 32'h1);
            prog(0, m, c ^ (32'h80000000 >> t)); prog(1, m, c);
            send(70, 1'b0, g, a);
            chk("R8 sparse mask slot1 only", 32'(g), 32'h2);
        end

        // R5: bytes past 64 do not contribute
        fill(7);
        m = '1; c = exp_crc(m, 64);
        prog(0, m, c); prog(1, m, ~c);
        send(100, 1'b0, g, a);
        chk("R5 long frame", 32'(g), 32'h1);
        for (int i = 64; i < 128; i++) fb[i] = ~fb[i];
        send(120, 1'b0, g, a);
        chk("R5 changed tail", 32'(g), 32'h1);

        // R6: frame shorter than highest selected byte
        fill(9);
        m = (64'h1 << 2) | (64'h1 << 40);
        prog(0, m, exp_crc(m, 30)); prog(1, 64'h0, 32'h0);
        send(30, 1'b0, g, a);
        chk("R6 short frame", 32'(g), 32'h0);
        prog(0, m, exp_crc(m, 41));
        send(41, 1'b0, g, a);
        chk("R6 frame reaching last byte", 32'(g), 32'h1);

        // R7: zero mask with zero expected (the empty CRC)
        prog(0, 64'h0, 32'h0); prog(1, 64'h0, 32'h0);
        send(20, 1'b0, g, a);
        chk("R7 zero mask", 32'(g), 32'h0);
        send(1, 1'b0, g, a);
        chk("R7 zero mask one byte", 32'(g), 32'h0);

        // R9: writes during a frame do not affect it
        fill(21);
        m = 64'h00F0_0000_0F0F_00FF; c = exp_crc(m, 64);
        prog(0, m, c); prog(1, 64'h0, 32'h0);
        send(64, 1'b1, g, a);
        chk("R9 mid-frame write ignored", 32'(g), 32'h1);
        send(64, 1'b0, g, a);
        chk("R9 write applies next frame", 32'(g), 32'h0);

        // R10: idle bytes ignored, second start restarts
        fill(33);
        m = 64'h0000_0000_0000_F00F; c = exp_crc(m, 64);
        prog(0, m, c); prog(1, 64'h0, 32'h0);
        rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b1; rx_data = 8'h55;
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        chk("R10 idle eof ignored", 32'(match_o), 32'h0);
        for (int i = 0; i < 5; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'(i * 3);
            @(negedge clk);
        end
        send(64, 1'b0, g, a);
        chk("R10 idle bytes ignored", 32'(g), 32'h1);
        for (int i = 0; i < 7; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'(i * 29 + 1);
            @(negedge clk);
        end
        send(64, 1'b0, g, a);
        chk("R10 restart on second start", 32'(g), 32'h1);

        // R11: one-byte frame
        fill(44);
        m = 64'h1; c = exp_crc(m, 1);
        prog(0, m, c); prog(1, m, ~c);
        send(1, 1'b0, g, a);
        chk("R11 one-byte frame", 32'(g), 32'h1);
        chk("R11 pulse ends", 32'(a), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule